// File: doc/BRIEF.md
# Filter-Chain Memory Request Scheduler

This block holds pending memory requests in a small registry and, every cycle, chooses the next one to hand to the DRAM command generator. Two enqueue ports accept new requests. Each request is a read or a write to a location given by bank, row and column. One issue port offers the chosen request. The choice comes from a single-cycle chain of filters. The chain removes requests that cannot proceed for lack of buffer space or write data. It then removes requests that must wait behind an older access to the same location. Next it prefers hits on an open row, and then reads over writes. It removes requests to a bank that the timing tracker reports as locked. Of whatever remains, the oldest request is offered.

Ordering hazards are not found by comparing every entry against every other entry. Each entry keeps a record of the older entries it depends on. That record is filled when the request enters, by comparing it against the registry, and bits are cleared as entries leave. The comparator count therefore grows linearly with depth. An age matrix, updated in the same way, gives the relative age of any two entries.

Both enqueue ports and the issue port use valid/ready. An enqueue port takes its request in a cycle where valid and ready are both high. Readiness depends only on the registry occupancy at the start of the cycle, so an issue in the same cycle does not free a slot for that cycle. The issue offer is recomputed every cycle from the registry and the status inputs. It may therefore change or drop while iss_ready is low. The request leaves the registry only in a cycle where iss_valid and iss_ready are both high. Write data readiness arrives as a plain pulse: the write buffer is filled in request order.

Top module: `rq_sched`

## Requirements
- R1: After reset the registry is empty, iss_valid is low and both enqueue ports are ready.
- R2: enq0_ready is high when at least one slot is free, and enq1_ready is high when at least two slots are free, both judged at the start of the cycle. When both ports enqueue in the same cycle, the port 0 request counts as older.
- R3: A read can issue only while rd_buf_free is 1. A write can issue only after its data has been marked present.
- R4: A wdata_fill pulse marks the oldest write still waiting for data. A pulse while no write is waiting has no effect.
- R5: Two requests conflict when they have the same bank, row and column and at least one of them is a write. The younger of two conflicting requests cannot issue while the older one is still in the registry.
- R6: A request hits when bank_open of its bank is 1 and the open_row field of that bank (bits bank*ROW_W upward) equals its row. When any request still in the chain hits, requests that miss are dropped.
- R7: After the page filter, writes are dropped when any read remains.
- R8: The lock filter acts after the page and read filters. A request whose bank has bank_locked set is dropped, and no request that an earlier filter removed is offered in its place.
- R9: Among the requests left after all filters, the oldest is offered on the issue port. It leaves the registry on the iss_valid and iss_ready handshake, and nothing is offered when no request survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq0_valid | input | 1 | Port 0 request present |
| enq0_ready | output | 1 | Port 0 can accept |
| enq0_wr | input | 1 | Port 0 request is a write |
| enq0_bank | input | BANK_W | Port 0 bank |
| enq0_row | input | ROW_W | Port 0 row |
| enq0_col | input | COL_W | Port 0 column |
| enq1_valid | input | 1 | Port 1 request present |
| enq1_ready | output | 1 | Port 1 can accept |
| enq1_wr | input | 1 | Port 1 request is a write |
| enq1_bank | input | BANK_W | Port 1 bank |
| enq1_row | input | ROW_W | Port 1 row |
| enq1_col | input | COL_W | Port 1 column |
| wdata_fill | input | 1 | Data for the oldest waiting write has arrived |
| rd_buf_free | input | 1 | Read data buffer has a free slot |
| bank_locked | input | BANKS | Per-bank timing lock from the tracker |
| bank_open | input | BANKS | Per-bank row open flag |
| open_row | input | BANKS*ROW_W | Open row of each bank |
| iss_valid | output | 1 | A request is offered |
| iss_ready | input | 1 | Command generator takes the offer |
| iss_wr | output | 1 | Offered request is a write |
| iss_bank | output | BANK_W | Offered bank |
| iss_row | output | ROW_W | Offered row |
| iss_col | output | COL_W | Offered column |

## Verification
A corrupted age or dependency record shows up at the issue port in the same cycle: a younger request is offered ahead of an older one, or a read slips past a write to the same location. A lost write-ready flag shows up as a write that is never offered, while a stale valid bit shows up as wrong ready levels on the enqueue ports. The bench compares every cycle's offer and ready levels with an ordered reference model, so any such fault is seen in the first cycle in which it changes the choice.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int BANKS  = 4;
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;

  typedef struct packed {
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } req_t;

  // same location and at least one side writes
  function automatic logic conflicts(req_t a, req_t b);
    return (a.bank == b.bank) && (a.row == b.row) && (a.col == b.col) && (a.wr || b.wr);
  endfunction
endpackage

// File: rtl/rq_oldest_pick.sv
module rq_oldest_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]        mask,
  input  logic [N-1:0][N-1:0] older,   // older[i][j]: entry j precedes entry i
  output logic [N-1:0]        pick
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      pick[i] = mask[i] & ~(|(mask & older[i]));
    end
  end
endmodule

// File: rtl/rq_slot_alloc.sv
module rq_slot_alloc #(
  parameter int N = 8
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] slot0,
  output logic [N-1:0] slot1,
  output logic         have1,
  output logic         have2
);
  always_comb begin
    slot0 = '0;
    slot1 = '0;
    have1 = 1'b0;
    have2 = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i]) begin
        if (!have1) begin
          slot0[i] = 1'b1;
          have1    = 1'b1;
        end else if (!have2) begin
          slot1[i] = 1'b1;
          have2    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rq_filter_chain.sv
module rq_filter_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0]        valid,
  input  logic [N-1:0]        is_wr,
  input  logic [N-1:0]        wrdy,
  input  logic [N-1:0]        hazard,
  input  logic [N-1:0]        page_hit,
  input  logic [N-1:0]        locked,
  input  logic                rd_free,
  input  logic [N-1:0][N-1:0] older,
  output logic [N-1:0]        grant
);
  logic [N-1:0] s_res, s_dep, s_pg, s_rd, s_lk;

  always_comb begin
    s_res = valid & ((is_wr & wrdy) | (~is_wr & {N{rd_free}}));
    s_dep = s_res & ~hazard;
    s_pg  = (|(s_dep & page_hit)) ? (s_dep & page_hit) : s_dep;
    s_rd  = (|(s_pg & ~is_wr)) ? (s_pg & ~is_wr) : s_pg;
    s_lk  = s_rd & ~locked;
  end

  rq_oldest_pick #(.N(N)) u_age (
    .mask  (s_lk),
    .older (older),
    .pick  (grant)
  );
endmodule

// File: rtl/rq_sched.sv
module rq_sched
  import rq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enq0_valid,
  output logic                   enq0_ready,
  input  logic                   enq0_wr,
  input  logic [BANK_W-1:0]      enq0_bank,
  input  logic [ROW_W-1:0]       enq0_row,
  input  logic [COL_W-1:0]       enq0_col,
  input  logic                   enq1_valid,
  output logic                   enq1_ready,
  input  logic                   enq1_wr,
  input  logic [BANK_W-1:0]      enq1_bank,
  input  logic [ROW_W-1:0]       enq1_row,
  input  logic [COL_W-1:0]       enq1_col,
  input  logic                   wdata_fill,
  input  logic                   rd_buf_free,
  input  logic [BANKS-1:0]       bank_locked,
  input  logic [BANKS-1:0]       bank_open,
  input  logic [BANKS*ROW_W-1:0] open_row,
  output logic                   iss_valid,
  input  logic                   iss_ready,
  output logic                   iss_wr,
  output logic [BANK_W-1:0]      iss_bank,
  output logic [ROW_W-1:0]       iss_row,
  output logic [COL_W-1:0]       iss_col
);
  localparam int RW = $bits(req_t);

  logic [DEPTH-1:0]            valid_q, wrdy_q;
  logic [DEPTH-1:0][DEPTH-1:0] older_q, dep_q;
  req_t                        req_q [DEPTH];

  logic [ROW_W-1:0] orow [BANKS];
  for (genvar b = 0; b < BANKS; b++) begin : g_orow
    assign orow[b] = open_row[b*ROW_W +: ROW_W];
  end

  // per-entry views feeding the filter chain
  logic [DEPTH-1:0] is_wr, hazard, page_hit, locked;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      is_wr[i]    = req_q[i].wr;
      hazard[i]   = |dep_q[i];
      page_hit[i] = bank_open[req_q[i].bank] && (orow[req_q[i].bank] == req_q[i].row);
      locked[i]   = bank_locked[req_q[i].bank];
    end
  end

  logic [DEPTH-1:0] grant;
  rq_filter_chain #(.N(DEPTH)) u_chain (
    .valid    (valid_q),
    .is_wr    (is_wr),
    .wrdy     (wrdy_q),
    .hazard   (hazard),
    .page_hit (page_hit),
    .locked   (locked),
    .rd_free  (rd_buf_free),
    .older    (older_q),
    .grant    (grant)
  );

  req_t iss_req;
  always_comb begin
    iss_req = '0;
    for (int i = 0; i < DEPTH; i++) begin
      iss_req = iss_req | (req_q[i] & {RW{grant[i]}});
    end
  end

  assign iss_valid = |grant;
  assign iss_wr    = iss_req.wr;
  assign iss_bank  = iss_req.bank;
  assign iss_row   = iss_req.row;
  assign iss_col   = iss_req.col;

  logic [DEPTH-1:0] gone, live;
  assign gone = (iss_valid && iss_ready) ? grant : '0;
  assign live = valid_q & ~gone;

  // slot allocation and enqueue handshakes
  logic [DEPTH-1:0] slot0, slot1;
  logic             have1, have2;
  rq_slot_alloc #(.N(DEPTH)) u_alloc (
    .busy  (valid_q),
    .slot0 (slot0),
    .slot1 (slot1),
    .have1 (have1),
    .have2 (have2)
  );
  assign enq0_ready = have1;
  assign enq1_ready = have2;

  logic fire0, fire1;
  assign fire0 = enq0_valid && enq0_ready;
  assign fire1 = enq1_valid && enq1_ready;

  req_t e0, e1;
  assign e0 = '{wr: enq0_wr, bank: enq0_bank, row: enq0_row, col: enq0_col};
  assign e1 = '{wr: enq1_wr, bank: enq1_bank, row: enq1_row, col: enq1_col};

  // comparison ports: each new request against the registry
  logic [DEPTH-1:0] match0, match1;
  logic             pair_conf;
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      match0[j] = conflicts(e0, req_q[j]);
      match1[j] = conflicts(e1, req_q[j]);
    end
    pair_conf = conflicts(e0, e1);
  end

  // write data arrives in request order: oldest waiting write gets it
  logic [DEPTH-1:0] fill_oh;
  rq_oldest_pick #(.N(DEPTH)) u_fill (
    .mask  (valid_q & is_wr & ~wrdy_q),
    .older (older_q),
    .pick  (fill_oh)
  );

  logic [DEPTH-1:0] new0, new1;
  assign new0 = fire0 ? slot0 : '0;
  assign new1 = fire1 ? slot1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      wrdy_q  <= '0;
      older_q <= '0;
      dep_q   <= '0;
    end else begin
      valid_q <= live | new0 | new1;
      wrdy_q  <= (wrdy_q | (wdata_fill ? fill_oh : '0)) & ~new0 & ~new1;
      for (int i = 0; i < DEPTH; i++) begin
        if (new0[i]) begin
          older_q[i] <= live;
          dep_q[i]   <= live & match0;
        end else if (new1[i]) begin
          older_q[i] <= live | new0;
          dep_q[i]   <= (live & match1) | (pair_conf ? new0 : '0);
        end else begin
          older_q[i] <= older_q[i] & ~gone;
          dep_q[i]   <= dep_q[i] & ~gone;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (new0[i]) req_q[i] <= e0;
      else if (new1[i]) req_q[i] <= e1;
    end
  end
endmodule

// File: rtl/rq_sched_chk.sv
module rq_sched_chk
  import rq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq0_valid,
  input logic              enq0_ready,
  input logic              enq1_valid,
  input logic              enq1_ready,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic              iss_wr,
  input logic [BANK_W-1:0] iss_bank,
  input logic              rd_buf_free,
  input logic [BANKS-1:0]  bank_locked
);
  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(enq0_valid && enq0_ready) + CW'(enq1_valid && enq1_ready)
                    - CW'(iss_valid && iss_ready);
  end

  p_one_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq0_ready == (occ < CW'(DEPTH)));
  p_two_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq1_ready == ((occ + CW'(1)) < CW'(DEPTH)));
  p_read_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_wr) |-> rd_buf_free);
  p_no_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !bank_locked[iss_bank]);
  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !iss_valid);
endmodule

bind rq_sched rq_sched_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enq0_valid  (enq0_valid),
  .enq0_ready  (enq0_ready),
  .enq1_valid  (enq1_valid),
  .enq1_ready  (enq1_ready),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_wr      (iss_wr),
  .iss_bank    (iss_bank),
  .rd_buf_free (rd_buf_free),
  .bank_locked (bank_locked)
);

// File: tb/rq_sched_tb.sv
module rq_sched_tb;
  import rq_pkg::*;
  localparam int D = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic enq0_valid, enq0_ready, enq0_wr;
  logic [BANK_W-1:0] enq0_bank;
  logic [ROW_W-1:0] enq0_row;
  logic [COL_W-1:0] enq0_col;
  logic enq1_valid, enq1_ready, enq1_wr;
  logic [BANK_W-1:0] enq1_bank;
  logic [ROW_W-1:0] enq1_row;
  logic [COL_W-1:0] enq1_col;
  logic wdata_fill, rd_buf_free;
  logic [BANKS-1:0] bank_locked, bank_open;
  logic [BANKS*ROW_W-1:0] open_row;
  logic iss_valid, iss_ready, iss_wr;
  logic [BANK_W-1:0] iss_bank;
  logic [ROW_W-1:0] iss_row;
  logic [COL_W-1:0] iss_col;

  rq_sched #(.DEPTH(D)) u_dut (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model: ordered by sequence number
  int m_v[D], m_wr[D], m_b[D], m_r[D], m_c[D], m_rdy[D], m_seq[D];
  int nseq = 0;

  function automatic int mfree();
    int n = 0;
    for (int i = 0; i < D; i++) if (!m_v[i]) n++;
    return n;
  endfunction

  function automatic int mcount();
    return D - mfree();
  endfunction

  function automatic int mpick();
    bit s[D];
    bit any;
    int best;
    for (int i = 0; i < D; i++) begin
      s[i] = m_v[i] != 0 && (m_wr[i] != 0 ? m_rdy[i] != 0 : rd_buf_free == 1'b1);
      for (int j = 0; j < D; j++)
        if (m_v[i] != 0 && m_v[j] != 0 && m_seq[j] < m_seq[i] && m_b[j] == m_b[i] &&
            m_r[j] == m_r[i] && m_c[j] == m_c[i] && (m_wr[i] != 0 || m_wr[j] != 0)) s[i] = 0;
    end
    any = 0;
    for (int i = 0; i < D; i++)
      if (s[i] && bank_open[m_b[i]] && open_row[m_b[i]*ROW_W +: ROW_W] == ROW_W'(m_r[i])) any = 1;
    if (any)
      for (int i = 0; i < D; i++)
        if (!(bank_open[m_b[i]] && open_row[m_b[i]*ROW_W +: ROW_W] == ROW_W'(m_r[i]))) s[i] = 0;
    any = 0;
    for (int i = 0; i < D; i++) if (s[i] && m_wr[i] == 0) any = 1;
    if (any) for (int i = 0; i < D; i++) if (m_wr[i] != 0) s[i] = 0;
    for (int i = 0; i < D; i++) if (bank_locked[m_b[i]]) s[i] = 0;
    best = -1;
    for (int i = 0; i < D; i++)
      if (s[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
    return best;
  endfunction

  task automatic madd(int wr, int b, int r, int c);
    for (int i = 0; i < D; i++) begin
      if (!m_v[i]) begin
        m_v[i] = 1; m_wr[i] = wr; m_b[i] = b; m_r[i] = r; m_c[i] = c;
        m_rdy[i] = 0; m_seq[i] = nseq++;
        return;
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d exp %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: inputs are already driven at the falling edge
  task automatic cyc(string tag);
    int p, fr, w;
    bit f0, f1;
    #1;
    fr = mfree();
    p = mpick();
    chk(tag, "enq0_ready", int'(enq0_ready), int'(fr >= 1));
    chk(tag, "enq1_ready", int'(enq1_ready), int'(fr >= 2));
    chk(tag, "iss_valid", int'(iss_valid), int'(p >= 0));
    if (p >= 0 && iss_valid) begin
      chk(tag, "iss_wr", int'(iss_wr), m_wr[p]);
      chk(tag, "iss_bank", int'(iss_bank), m_b[p]);
      chk(tag, "iss_row", int'(iss_row), m_r[p]);
      chk(tag, "iss_col", int'(iss_col), m_c[p]);
    end
    f0 = enq0_valid && fr >= 1;
    f1 = enq1_valid && fr >= 2;
    if (p >= 0 && iss_ready) m_v[p] = 0;
    if (wdata_fill) begin
      w = -1;
      for (int i = 0; i < D; i++)
        if (m_v[i] != 0 && m_wr[i] != 0 && m_rdy[i] == 0 && (w < 0 || m_seq[i] < m_seq[w])) w = i;
      if (w >= 0) m_rdy[w] = 1;
    end
    if (f0) madd(int'(enq0_wr), int'(enq0_bank), int'(enq0_row), int'(enq0_col));
    if (f1) madd(int'(enq1_wr), int'(enq1_bank), int'(enq1_row), int'(enq1_col));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    enq0_valid = 0; enq1_valid = 0; wdata_fill = 0;
  endtask

  task automatic put0(int wr, int b, int r, int c);
    enq0_valid = 1; enq0_wr = wr[0]; enq0_bank = BANK_W'(b); enq0_row = ROW_W'(r); enq0_col = COL_W'(c);
  endtask

  task automatic put1(int wr, int b, int r, int c);
    enq1_valid = 1; enq1_wr = wr[0]; enq1_bank = BANK_W'(b); enq1_row = ROW_W'(r); enq1_col = COL_W'(c);
  endtask

  task automatic drain();
    idle();
    iss_ready = 1; rd_buf_free = 1; bank_locked = '0; wdata_fill = 1;
    for (int k = 0; k < 40 && mcount() > 0; k++) cyc("R9");
    wdata_fill = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    for (int i = 0; i < D; i++) m_v[i] = 0;
    rst_n = 0; idle();
    enq0_wr = 0; enq0_bank = '0; enq0_row = '0; enq0_col = '0;
    enq1_wr = 0; enq1_bank = '0; enq1_row = '0; enq1_col = '0;
    rd_buf_free = 1; bank_locked = '0; bank_open = '0; open_row = '0; iss_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cyc("R1");

    // R3: read waits for a free read slot
    rd_buf_free = 0; put0(0, 0, 1, 1); cyc("R3");
    idle(); cyc("R3"); cyc("R3");
    rd_buf_free = 1; cyc("R3"); cyc("R3");

    // R4: a fill with no waiting write is ignored, then a write waits for its data
    wdata_fill = 1; cyc("R4");
    idle(); put0(1, 2, 3, 4); cyc("R4");
    idle(); cyc("R3"); cyc("R3");
    wdata_fill = 1; cyc("R4");
    wdata_fill = 0; cyc("R4"); cyc("R4");

    // R5: younger read to the same location waits behind the older write
    put0(1, 1, 2, 3); put1(0, 1, 2, 3); cyc("R5");
    idle(); cyc("R5"); cyc("R5");
    wdata_fill = 1; cyc("R5");
    wdata_fill = 0; cyc("R5"); cyc("R5"); cyc("R5");
    drain();

    // R6: a younger page hit goes before an older miss
    bank_open = 4'b0010; open_row = '0; open_row[1*ROW_W +: ROW_W] = 3;
    put0(0, 0, 0, 0); put1(0, 1, 3, 0); cyc("R6");
    idle(); cyc("R6"); cyc("R6"); cyc("R6");
    drain();

    // R7: a younger read goes before a ready older write
    bank_open = '0;
    put0(1, 2, 1, 1); cyc("R7");
    idle(); wdata_fill = 1; cyc("R7");
    wdata_fill = 0; put0(0, 3, 1, 1); cyc("R7");
    idle(); cyc("R7"); cyc("R7"); cyc("R7");
    drain();

    // R8: a locked page hit blocks the miss it displaced
    bank_open = 4'b0010; open_row[1*ROW_W +: ROW_W] = 3;
    put0(0, 2, 0, 0); put1(0, 1, 3, 5); bank_locked = 4'b0010; cyc("R8");
    idle(); cyc("R8"); cyc("R8");
    bank_locked = '0; cyc("R8"); cyc("R8"); cyc("R8");
    drain();
    bank_open = '0;

    // R2: fill the registry with back-pressure on the issue side
    iss_ready = 0;
    for (int k = 0; k < 5; k++) begin
      put0(0, k % 4, 0, 2 * k); put1(0, (k + 1) % 4, 1, 2 * k + 1); cyc("R2");
    end
    idle(); iss_ready = 1;
    for (int k = 0; k < 10; k++) cyc("R9");
    drain();

    // constrained random traffic with a fixed seed
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 3000; k++) begin
      enq0_valid = ($urandom % 2) == 0;
      enq0_wr = $urandom % 2; enq0_bank = BANK_W'($urandom % BANKS);
      enq0_row = ROW_W'($urandom % 2); enq0_col = COL_W'($urandom % 2);
      enq1_valid = ($urandom % 3) == 0;
      enq1_wr = $urandom % 2; enq1_bank = BANK_W'($urandom % BANKS);
      enq1_row = ROW_W'($urandom % 2); enq1_col = COL_W'($urandom % 2);
      wdata_fill = ($urandom % 10) < 3;
      rd_buf_free = ($urandom % 4) != 0;
      iss_ready = ($urandom % 10) < 7;
      for (int b = 0; b < BANKS; b++) begin
        bank_locked[b] = ($urandom % 5) == 0;
        bank_open[b] = $urandom % 2;
        open_row[b*ROW_W +: ROW_W] = ROW_W'($urandom % 2);
      end
      cyc("R9");
    end
    drain();
    summary();
  end
endmodule